// File: doc/BRIEF.md
# Doubleword Barrel Shifter

This block is the shift unit of a 64-bit integer execution stage. It is purely combinational. It takes the six-bit function code of a register-format instruction and the five-bit immediate shift field from the instruction word. It also takes a 64-bit register value that supplies the variable amount and the 64-bit operand to be shifted. It returns the 64-bit shifted result in the same cycle.

Three directions are supported: left, logical right and arithmetic right. Each comes in three amount sources. The first is the immediate field. The second is the immediate field with 32 added, which exists only at doubleword width. The third is the variable register, masked to 5 bits at word width and to 6 bits at doubleword width. Word-width operations use only the low half of the operand. Their 32-bit result is always sign-extended into the upper half. A function code that is not a shift produces an all-zero result.

Top module: `dw_shifter`

## Requirements
- R1: Function codes 0 (left), 2 (logical right) and 3 (arithmetic right) shift the low 32 bits of `src_i` by `sa_i`.
- R2: Function codes 4 (left), 6 (logical right) and 7 (arithmetic right) shift the low 32 bits of `src_i` by `amt_i[4:0]`.
- R3: Function codes 56 (left), 58 (logical right) and 59 (arithmetic right) shift all 64 bits of `src_i` by `sa_i`.
- R4: Function codes 60 (left), 62 (logical right) and 63 (arithmetic right) shift all 64 bits of `src_i` by `sa_i` + 32.
- R5: Function codes 20 (left), 22 (logical right) and 23 (arithmetic right) shift all 64 bits of `src_i` by `amt_i[5:0]`.
- R6: Arithmetic right shifts fill vacated bits with the operand's sign bit: bit 63 at doubleword width, bit 31 at word width.
- R7: Logical right shifts and left shifts fill vacated bits with zeros.
- R8: Every word-width result has bits 63:32 equal to copies of result bit 31. This includes logical right shifts.
- R9: A zero shift amount returns the operand unchanged at doubleword width, and the sign-extended low word at word width.
- R10: Any function code not listed in R1 to R5 gives a result of zero.
- R11: Bits of `amt_i` above the width mask (bits 63:5 for word forms, bits 63:6 for doubleword forms) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funct_i | input | 6 | Instruction function code |
| sa_i | input | 5 | Immediate shift amount field |
| amt_i | input | 64 | Register holding the variable shift amount |
| src_i | input | 64 | Operand to shift |
| result_o | output | 64 | Shifted result |

## Verification
The block has no state, so a fault in decode, amount selection or a shifter stage shows on `result_o` in the same evaluation as the inputs that exercise it. A wrong stage typically corrupts only the results whose amount has that stage's bit set. For that reason, the stimulus sweeps amounts across all six bit positions for every function code, and it includes directed vectors at 0, 31, 32 and 63. An error in the word-width fill or in the sign extension shows only when bit 31 of the intermediate result is set. Operands with bit 31 and bit 63 set are therefore included on purpose.

// File: rtl/dw_shifter_pkg.sv
package dw_shifter_pkg;

  localparam int FUNCT_W = 6;

  localparam logic [FUNCT_W-1:0] FN_WL_IMM   = 6'd0;
  localparam logic [FUNCT_W-1:0] FN_WRL_IMM  = 6'd2;
  localparam logic [FUNCT_W-1:0] FN_WRA_IMM  = 6'd3;
  localparam logic [FUNCT_W-1:0] FN_WL_VAR   = 6'd4;
  localparam logic [FUNCT_W-1:0] FN_WRL_VAR  = 6'd6;
  localparam logic [FUNCT_W-1:0] FN_WRA_VAR  = 6'd7;
  localparam logic [FUNCT_W-1:0] FN_DL_VAR   = 6'd20;
  localparam logic [FUNCT_W-1:0] FN_DRL_VAR  = 6'd22;
  localparam logic [FUNCT_W-1:0] FN_DRA_VAR  = 6'd23;
  localparam logic [FUNCT_W-1:0] FN_DL_IMM   = 6'd56;
  localparam logic [FUNCT_W-1:0] FN_DRL_IMM  = 6'd58;
  localparam logic [FUNCT_W-1:0] FN_DRA_IMM  = 6'd59;
  localparam logic [FUNCT_W-1:0] FN_DL_HI    = 6'd60;
  localparam logic [FUNCT_W-1:0] FN_DRL_HI   = 6'd62;
  localparam logic [FUNCT_W-1:0] FN_DRA_HI   = 6'd63;

  typedef enum logic [1:0] {
    DIR_LEFT   = 2'd0,
    DIR_RLOG   = 2'd1,
    DIR_RARITH = 2'd2
  } shf_dir_e;

  typedef enum logic [1:0] {
    AMT_IMM   = 2'd0,
    AMT_IMM32 = 2'd1,
    AMT_VAR   = 2'd2
  } shf_amt_e;

  typedef struct packed {
    logic     valid;
    logic     dword;
    shf_dir_e dir;
    shf_amt_e amt_src;
  } shf_ctrl_t;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import dw_shifter_pkg::*;
(
  input  logic [FUNCT_W-1:0] funct_i,
  output shf_ctrl_t          ctrl_o
);

  always_comb begin
    ctrl_o = '{valid: 1'b1, dword: 1'b0, dir: DIR_LEFT, amt_src: AMT_IMM};
    unique case (funct_i)
      FN_WL_IMM:  ctrl_o = '{1'b1, 1'b0, DIR_LEFT,   AMT_IMM};
      FN_WRL_IMM: ctrl_o = '{1'b1, 1'b0, DIR_RLOG,   AMT_IMM};
      FN_WRA_IMM: ctrl_o = '{1'b1, 1'b0, DIR_RARITH, AMT_IMM};
      FN_WL_VAR:  ctrl_o = '{1'b1, 1'b0, DIR_LEFT,   AMT_VAR};
      FN_WRL_VAR: ctrl_o = '{1'b1, 1'b0, DIR_RLOG,   AMT_VAR};
      FN_WRA_VAR: ctrl_o = '{1'b1, 1'b0, DIR_RARITH, AMT_VAR};
      FN_DL_VAR:  ctrl_o = '{1'b1, 1'b1, DIR_LEFT,   AMT_VAR};
      FN_DRL_VAR: ctrl_o = '{1'b1, 1'b1, DIR_RLOG,   AMT_VAR};
      FN_DRA_VAR: ctrl_o = '{1'b1, 1'b1, DIR_RARITH, AMT_VAR};
      FN_DL_IMM:  ctrl_o = '{1'b1, 1'b1, DIR_LEFT,   AMT_IMM};
      FN_DRL_IMM: ctrl_o = '{1'b1, 1'b1, DIR_RLOG,   AMT_IMM};
      FN_DRA_IMM: ctrl_o = '{1'b1, 1'b1, DIR_RARITH, AMT_IMM};
      FN_DL_HI:   ctrl_o = '{1'b1, 1'b1, DIR_LEFT,   AMT_IMM32};
      FN_DRL_HI:  ctrl_o = '{1'b1, 1'b1, DIR_RLOG,   AMT_IMM32};
      FN_DRA_HI:  ctrl_o = '{1'b1, 1'b1, DIR_RARITH, AMT_IMM32};
      default:    ctrl_o = '{1'b0, 1'b0, DIR_LEFT,   AMT_IMM};
    endcase
  end

  // R4: the plus-32 source exists only at doubleword width
  always_comb begin
    if (ctrl_o.valid && ctrl_o.amt_src == AMT_IMM32)
      a_r4_hi_is_dword: assert (ctrl_o.dword);
  end

endmodule

// File: rtl/shf_amount.sv
module shf_amount
  import dw_shifter_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SA_W   = 5,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  shf_ctrl_t         ctrl_i,
  input  logic [SA_W-1:0]   sa_i,
  input  logic [DATA_W-1:0] var_i,
  output logic [AMT_W-1:0]  amt_o
);

  logic unused_hi;
  assign unused_hi = ^var_i[DATA_W-1:AMT_W];

  always_comb begin
    unique case (ctrl_i.amt_src)
      AMT_IMM32: amt_o = {1'b1, sa_i};
      AMT_VAR:   amt_o = ctrl_i.dword ? var_i[AMT_W-1:0] : {1'b0, var_i[AMT_W-2:0]};
      default:   amt_o = {1'b0, sa_i};
    endcase
  end

  // R2: word forms never shift by more than half the width minus one
  always_comb begin
    if (ctrl_i.valid && !ctrl_i.dword)
      a_r2_word_amt_range: assert (amt_o < AMT_W'(DATA_W / 2));
  end

endmodule

// File: rtl/shf_core.sv
module shf_core
  import dw_shifter_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shf_dir_e          dir_i,
  input  logic              dword_i,
  output logic [DATA_W-1:0] out_o
);

  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] base_rev;
  logic [DATA_W-1:0] stage_in;
  logic              fill;
  logic [DATA_W-1:0] st [AMT_W+1];
  logic [DATA_W-1:0] st_rev;

  // word forms: upper half preloaded with the right-shift fill
  always_comb begin
    if (dword_i) base = src_i;
    else if (dir_i == DIR_RARITH) base = {{HALF_W{src_i[HALF_W-1]}}, src_i[HALF_W-1:0]};
    else base = {{HALF_W{1'b0}}, src_i[HALF_W-1:0]};
  end

  // left shift runs through the right shifter on bit-reversed data
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_in
    assign base_rev[i] = base[DATA_W-1-i];
  end

  assign stage_in = (dir_i == DIR_LEFT) ? base_rev : base;
  assign fill     = (dir_i == DIR_RARITH) && base[DATA_W-1];
  assign st[0]    = stage_in;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign st[k+1] = amt_i[k] ? {{SH{fill}}, st[k][DATA_W-1:SH]} : st[k];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_out
    assign st_rev[i] = st[AMT_W][DATA_W-1-i];
  end

  assign out_o = (dir_i == DIR_LEFT) ? st_rev : st[AMT_W];

  // R7: a nonzero logical right shift at full width clears the top bit
  always_comb begin
    if (dword_i && dir_i == DIR_RLOG && amt_i != '0)
      a_r7_rlog_zero_top: assert (!out_o[DATA_W-1]);
    if (dir_i == DIR_LEFT && amt_i != '0)
      a_r7_left_zero_bottom: assert (!out_o[0]);
  end

endmodule

// File: rtl/dw_shifter.sv
module dw_shifter
  import dw_shifter_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SA_W   = 5,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [SA_W-1:0]    sa_i,
  input  logic [DATA_W-1:0]  amt_i,
  input  logic [DATA_W-1:0]  src_i,
  output logic [DATA_W-1:0]  result_o
);

  shf_ctrl_t         ctrl;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] shifted;

  shf_decode u_decode (
    .funct_i (funct_i),
    .ctrl_o  (ctrl)
  );

  shf_amount #(.DATA_W(DATA_W), .SA_W(SA_W)) u_amount (
    .ctrl_i (ctrl),
    .sa_i   (sa_i),
    .var_i  (amt_i),
    .amt_o  (amt)
  );

  shf_core #(.DATA_W(DATA_W)) u_core (
    .src_i   (src_i),
    .amt_i   (amt),
    .dir_i   (ctrl.dir),
    .dword_i (ctrl.dword),
    .out_o   (shifted)
  );

  always_comb begin
    if (!ctrl.valid) result_o = '0;
    else if (ctrl.dword) result_o = shifted;
    else result_o = {{HALF_W{shifted[HALF_W-1]}}, shifted[HALF_W-1:0]};
  end

  always_comb begin
    if (ctrl.valid && !ctrl.dword)
      a_r8_word_sext: assert (result_o[DATA_W-1:HALF_W] == {HALF_W{result_o[HALF_W-1]}});
    if (!ctrl.valid)
      a_r10_invalid_zero: assert (result_o == '0);
    if (ctrl.valid && ctrl.dword && amt == '0)
      a_r9_zero_pass: assert (result_o == src_i);
    if (ctrl.valid && ctrl.dword && ctrl.dir == DIR_RARITH)
      a_r6_sign_kept: assert (result_o[DATA_W-1] == src_i[DATA_W-1]);
  end

endmodule

// File: tb/dw_shifter_tb.sv
module dw_shifter_tb;

  logic        clk;
  logic        rst_ni;
  logic [5:0]  funct;
  logic [4:0]  sa;
  logic [63:0] amt;
  logic [63:0] src;
  logic [63:0] result;
  int          n_checks;
  int          n_errors;

  dw_shifter u_dut (
    .funct_i  (funct),
    .sa_i     (sa),
    .amt_i    (amt),
    .src_i    (src),
    .result_o (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [5:0] CODES [15] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7,
                                        6'd20, 6'd22, 6'd23, 6'd56, 6'd58, 6'd59,
                                        6'd60, 6'd62, 6'd63};

  function automatic logic [63:0] ref_shift(input logic [5:0] f, input logic [4:0] s,
                                            input logic [63:0] v, input logic [63:0] x);
    logic [31:0] w;
    int          n;
    logic [63:0] r;
    w = 32'd0;
    r = 64'd0;
    case (f)
      6'd0, 6'd4: begin n = (f == 6'd0) ? int'(s) : int'(v[4:0]); w = x[31:0] << n; end
      6'd2, 6'd6: begin n = (f == 6'd2) ? int'(s) : int'(v[4:0]); w = x[31:0] >> n; end
      6'd3, 6'd7: begin n = (f == 6'd3) ? int'(s) : int'(v[4:0]); w = 32'($signed(x[31:0]) >>> n); end
      6'd56: r = x << s;
      6'd58: r = x >> s;
      6'd59: r = 64'($signed(x) >>> s);
      6'd60: r = x << (int'(s) + 32);
      6'd62: r = x >> (int'(s) + 32);
      6'd63: r = 64'($signed(x) >>> (int'(s) + 32));
      6'd20: r = x << v[5:0];
      6'd22: r = x >> v[5:0];
      6'd23: r = 64'($signed(x) >>> v[5:0]);
      default: r = 64'd0;
    endcase
    if (f inside {6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7}) r = {{32{w[31]}}, w};
    return r;
  endfunction

  function automatic string tag_of(input logic [5:0] f);
    if (f inside {6'd0, 6'd2, 6'd3}) return "R1";
    if (f inside {6'd4, 6'd6, 6'd7}) return "R2";
    if (f inside {6'd56, 6'd58, 6'd59}) return "R3";
    if (f inside {6'd60, 6'd62, 6'd63}) return "R4";
    if (f inside {6'd20, 6'd22, 6'd23}) return "R5";
    return "R10";
  endfunction

  task automatic apply_check(input string tag, input logic [5:0] f, input logic [4:0] s,
                             input logic [63:0] v, input logic [63:0] x);
    logic [63:0] exp;
    @(posedge clk);
    funct = f; sa = s; amt = v; src = x;
    @(negedge clk);
    exp = ref_shift(f, s, v, x);
    n_checks++;
    if (result !== exp) begin
      n_errors++;
      $display("FAIL %s funct=%0d sa=%0d amt=%h src=%h got=%h exp=%h",
               tag, f, s, v, x, result, exp);
    end
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [5:0]  f;
    logic [63:0] x;
    void'($urandom(32'd20240611));
    n_checks = 0; n_errors = 0;
    funct = 6'd1; sa = '0; amt = '0; src = '0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state: non-shift code with zero data gives zero (R10)
    apply_check("R10", 6'd1, 5'd0, 64'd0, 64'd0);

    // R6: arithmetic fill from bit 63 and from bit 31
    apply_check("R6", 6'd59, 5'd4,  64'd0, 64'h8000_0000_0000_0000);
    apply_check("R6", 6'd63, 5'd31, 64'd0, 64'h8000_0000_0000_0000);
    apply_check("R6", 6'd3,  5'd31, 64'd0, 64'h0000_0000_8000_0000);
    apply_check("R6", 6'd7,  5'd0,  64'd5, 64'h0000_0000_F000_0000);
    // R7: logical right and left zero fill
    apply_check("R7", 6'd58, 5'd1,  64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    apply_check("R7", 6'd22, 5'd0,  64'd63, 64'hFFFF_FFFF_FFFF_FFFF);
    apply_check("R7", 6'd56, 5'd31, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    // R8: word logical right with amount 0 still sign-extends
    apply_check("R8", 6'd2, 5'd0, 64'd0, 64'h1234_5678_8000_0001);
    apply_check("R8", 6'd0, 5'd31, 64'd0, 64'h0000_0000_0000_0001);
    // R9: zero amount passes through
    apply_check("R9", 6'd56, 5'd0, 64'd0, 64'hDEAD_BEEF_0123_4567);
    apply_check("R9", 6'd20, 5'd0, 64'h40, 64'hDEAD_BEEF_0123_4567);
    apply_check("R9", 6'd0,  5'd0, 64'd0, 64'hDEAD_BEEF_7123_4567);
    // R4: boundary amounts 32 and 63
    apply_check("R4", 6'd62, 5'd0,  64'd0, 64'h8765_4321_0FED_CBA9);
    apply_check("R4", 6'd60, 5'd31, 64'd0, 64'h0000_0000_0000_0001);
    // R11: upper amount bits ignored
    apply_check("R11", 6'd6,  5'd0, 64'hFFFF_FFFF_FFFF_FFE4, 64'hFFFF_FFFF_F0F0_F0F0);
    apply_check("R11", 6'd23, 5'd0, 64'hAAAA_AAAA_AAAA_AA45, 64'h8000_0000_0000_0000);
    // R10: unused codes
    apply_check("R10", 6'd1,  5'd3, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    apply_check("R10", 6'd57, 5'd3, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) f = 6'($urandom);
      else f = CODES[$urandom_range(0, 14)];
      x = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) x[63] = 1'b1;
      if ($urandom_range(0, 3) == 0) x[31] = 1'b1;
      apply_check(tag_of(f), f, 5'($urandom), {$urandom, $urandom}, x);
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule